// File: doc/BRIEF.md
# SDRAM Command Protocol Checker with Per-Bank State Tracking

This block sits beside the command bus of a four-bank double-data-rate mobile SDRAM. It observes the bus passively. On every rising clock edge it turns the control strobes into a command, works out which bank or banks the command targets, and judges it against the state and timers it keeps for each bank. One clock later it reports the decoded opcode, a legal flag and a violation code. All timing limits are parameters counted in clock cycles.

Each bank is closed, open, or waiting for an automatic close that was requested on a read or a write. A closed bank whose precharge time has not run out is treated as still precharging. When a command is legal it moves the bank state forward. When it is illegal it is reported, and no bank state or timer changes because of it. The timers keep counting whether or not a command is legal. Automatic precharge follows the mobile rules. After a read it starts half a burst after the command, or later if the minimum open time has not yet passed. After a write it starts once the burst and the write recovery time are over.

Top module: `sdram_cmd_checker`

## Requirements
- R1: While CKE is high and CS_n is low, the {RAS_n,CAS_n,WE_n} pattern decodes as follows: 111 is NOP (opcode 0), 011 is activate (1), 101 is read (2), 100 is write (3), 010 is precharge (4), 001 is refresh (5), 000 is mode-register set (6), and 110 is burst stop (7).
- R2: While CS_n is high, every pattern decodes as NOP. It is legal and has no effect.
- R3: While CKE is low, the command is reported as a legal NOP and leaves every bank unchanged.
- R4: The outputs for the command sampled at clock edge k appear after edge k. Legal is 1 with code 0. Illegal is 0 with a nonzero code: 1 wrong bank state, 2 tRCD, 3 tRP, 4 tRAS, 5 tWR. NOP, burst stop and mode-register set do not carry a bank address.
- R5: A command that meets its bank in the wrong state gets code 1 and changes no state or timer. Examples are a read or write to a closed bank, an activate to an open bank, and any bank command to a bank with an automatic precharge pending. Banks are independent of each other.
- R6: A read or write N cycles after the activate of its bank is legal only if N >= TRCD. Otherwise it gets code 2.
- R7: A precharge to an open bank N cycles after its activate gets code 4 when N < TRAS. A precharge to a closed bank is legal and has no effect.
- R8: A precharge N cycles after a write to that bank gets code 5 when N < BL/2+TWR.
- R9: An activate N cycles after its bank closed gets code 3 when N < TRP.
- R10: Refresh and mode-register set need every bank closed (otherwise code 1) and every precharge time expired (otherwise code 3).
- R11: A precharge with A10=1 closes every open bank. It is illegal if any bank would violate R5, R7 or R8. When several banks violate, the lowest-numbered failing bank supplies the code. With A10=0 only the bank on BA closes.
- R12: A read with A10=1 closes its bank at cycle max(c+BL/2, a+TRAS), where c is the read cycle and a is the activate cycle. The bank stays in state 1 up to and including that cycle, and then precharges for TRP cycles.
- R13: A write with A10=1 closes its bank at cycle max(c+BL/2+TWR, a+TRAS). It then behaves as in R12.
- R14: A synchronous active-low reset closes every bank with all timers expired and sets the outputs to a legal NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NUM_BANKS) | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| op_o | output | 3 | Decoded opcode of the previous command |
| legal_o | output | 1 | Previous command was legal |
| viol_o | output | 3 | Violation code of the previous command |

## Verification
A wrong bank state or a wrong timer shows up only when a later command reaches that bank. It then appears one cycle after that command as a wrong code, or as a legal flag that should not be set. The sweeps therefore vary the distance between two commands across each timing threshold, so that a timer off by one shows a changed verdict exactly at the boundary cycle. Each automatic-precharge sweep also varies the distance from activate to read or write, so that both terms of the close time become the limiting one. State that an illegal command should have left alone is checked by a follow-up command. Its verdict depends on whether the bank or its timer moved.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;
   typedef enum logic [2:0] {
      OP_NOP, OP_ACT, OP_RD, OP_WR, OP_PRE, OP_REF, OP_MRS, OP_BST
   } op_e;

   typedef enum logic [2:0] {
      V_OK, V_STATE, V_TRCD, V_TRP, V_TRAS, V_TWR
   } viol_e;

   typedef enum logic [1:0] {
      BK_IDLE, BK_OPEN, BK_RDAP, BK_WRAP
   } bank_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_chk_pkg::*;
(
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output op_e  op
);
   always_comb begin
      if (!cke || cs_n) begin
         op = OP_NOP;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111:  op = OP_NOP;
            3'b011:  op = OP_ACT;
            3'b101:  op = OP_RD;
            3'b100:  op = OP_WR;
            3'b010:  op = OP_PRE;
            3'b001:  op = OP_REF;
            3'b000:  op = OP_MRS;
            default: op = OP_BST;
         endcase
      end
   end
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
   import sdram_chk_pkg::*;
#(
   parameter int TRCD = 3,
   parameter int TRAS = 7,
   parameter int TRP  = 3,
   parameter int TWR  = 2,
   parameter int BLH  = 2,
   parameter int TW   = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  op_e   op,
   input  logic  hit,
   input  logic  ap,
   input  logic  accept,
   output viol_e viol
);
   localparam logic [TW-1:0] LD_RCD = TW'(TRCD - 1);
   localparam logic [TW-1:0] LD_RAS = TW'(TRAS - 1);
   localparam logic [TW-1:0] LD_RP  = TW'(TRP - 1);
   localparam logic [TW-1:0] LD_WR  = TW'(BLH + TWR - 1);
   localparam logic [TW-1:0] LD_RAP = TW'(BLH - 1);

   bank_e         st;
   logic [TW-1:0] rcd_t, ras_t, rp_t, wr_t, ap_t;
   logic          ap_pend;

   assign ap_pend = (st == BK_RDAP) || (st == BK_WRAP);

   always_comb begin
      viol = V_OK;
      if (hit) begin
         unique case (op)
            OP_ACT: begin
               if (st != BK_IDLE)  viol = V_STATE;
               else if (rp_t != 0) viol = V_TRP;
            end
            OP_RD, OP_WR: begin
               if (st != BK_OPEN)   viol = V_STATE;
               else if (rcd_t != 0) viol = V_TRCD;
            end
            OP_PRE: begin
               if (ap_pend) viol = V_STATE;
               else if (st == BK_OPEN && ras_t != 0) viol = V_TRAS;
               else if (st == BK_OPEN && wr_t != 0)  viol = V_TWR;
            end
            OP_REF, OP_MRS: begin
               if (st != BK_IDLE)  viol = V_STATE;
               else if (rp_t != 0) viol = V_TRP;
            end
            default: viol = V_OK;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= BK_IDLE;
         rcd_t <= '0;
         ras_t <= '0;
         rp_t  <= '0;
         wr_t  <= '0;
         ap_t  <= '0;
      end else begin
         if (rcd_t != 0) rcd_t <= rcd_t - 1'b1;
         if (ras_t != 0) ras_t <= ras_t - 1'b1;
         if (rp_t  != 0) rp_t  <= rp_t  - 1'b1;
         if (wr_t  != 0) wr_t  <= wr_t  - 1'b1;
         if (ap_t  != 0) ap_t  <= ap_t  - 1'b1;

         // automatic close: burst/recovery done and minimum open time met
         if (ap_pend && ap_t == 0 && ras_t == 0) begin
            st   <= BK_IDLE;
            rp_t <= LD_RP;
         end

         if (hit && accept) begin
            unique case (op)
               OP_ACT: begin
                  st    <= BK_OPEN;
                  rcd_t <= LD_RCD;
                  ras_t <= LD_RAS;
                  wr_t  <= '0;
               end
               OP_RD: begin
                  if (ap) begin
                     st   <= BK_RDAP;
                     ap_t <= LD_RAP;
                  end
               end
               OP_WR: begin
                  wr_t <= LD_WR;
                  if (ap) begin
                     st   <= BK_WRAP;
                     ap_t <= LD_WR;
                  end
               end
               OP_PRE: begin
                  if (st == BK_OPEN) begin
                     st   <= BK_IDLE;
                     rp_t <= LD_RP;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
   import sdram_chk_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BL        = 4,
   parameter int TRCD      = 3,
   parameter int TRAS      = 7,
   parameter int TRP       = 3,
   parameter int TWR       = 2,
   localparam int BAW      = $clog2(NUM_BANKS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cke,
   input  logic           cs_n,
   input  logic           ras_n,
   input  logic           cas_n,
   input  logic           we_n,
   input  logic [BAW-1:0] ba,
   input  logic           a10,
   output logic [2:0]     op_o,
   output logic           legal_o,
   output logic [2:0]     viol_o
);
   localparam int BLH  = BL / 2;
   localparam int M1   = (TRCD > TRAS) ? TRCD : TRAS;
   localparam int M2   = (TRP > BLH + TWR) ? TRP : BLH + TWR;
   localparam int MAXT = (M1 > M2) ? M1 : M2;
   localparam int TW   = $clog2(MAXT + 1);

   generate
      if (BL != 2 && BL != 4 && BL != 8) begin : g_bad_bl
         $error("BL must be 2, 4 or 8");
      end
      if (NUM_BANKS < 2 || (1 << BAW) != NUM_BANKS) begin : g_bad_nb
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (TWR < 2 || TRP < 1 || TRCD < 1 || TRAS < 1) begin : g_bad_t
         $error("timing limits below minimum (TWR>=2, TRP>=1 for tDAL>=3)");
      end
   endgenerate

   op_e   op;
   logic  all_bk;
   logic  accept;
   viol_e verdict;
   viol_e viol_b [NUM_BANKS];

   sdram_cmd_decode u_dec (
      .cke   (cke),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .op    (op)
   );

   assign all_bk = (op == OP_REF) || (op == OP_MRS) || (op == OP_PRE && a10);

   generate
      for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
         sdram_bank_fsm #(
            .TRCD (TRCD), .TRAS (TRAS), .TRP (TRP),
            .TWR  (TWR),  .BLH  (BLH),  .TW  (TW)
         ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .op     (op),
            .hit    (all_bk || (ba == BAW'(i))),
            .ap     (a10),
            .accept (accept),
            .viol   (viol_b[i])
         );
      end
   endgenerate

   // lowest-numbered failing bank supplies the code
   always_comb begin
      verdict = V_OK;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (verdict == V_OK && viol_b[i] != V_OK) verdict = viol_b[i];
      end
   end

   assign accept = (verdict == V_OK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_o    <= OP_NOP;
         legal_o <= 1'b1;
         viol_o  <= V_OK;
      end else begin
         op_o    <= op;
         legal_o <= accept;
         viol_o  <= verdict;
      end
   end
endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       cke,
   input logic       cs_n,
   input logic       ras_n,
   input logic       cas_n,
   input logic       we_n,
   input logic [2:0] op_o,
   input logic       legal_o,
   input logic [2:0] viol_o
);
   AST_DESELECT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && cs_n) |=> (op_o == 3'd0 && legal_o)); // R2

   AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> (op_o == 3'd0 && legal_o)); // R3

   AST_READ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !cs_n && ras_n && !cas_n && we_n) |=> (op_o == 3'd2)); // R1

   AST_ILLEGAL_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !legal_o |-> (viol_o != 3'd0 && viol_o <= 3'd5)); // R4

   AST_NOP_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (op_o == 3'd0 || op_o == 3'd7) |-> (legal_o && viol_o == 3'd0)); // R4
endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva u_sva (.*);

// File: tb/sdram_cmd_checker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_checker_tb;
   localparam int NB = 4, BL = 4, TRCD = 2, TRAS = 6, TRP = 2, TWR = 2;
   localparam int BLH = BL / 2;
   localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, REF = 5, MRS = 6, BST = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
   logic [1:0] ba = 2'd0;
   logic [2:0] op_o, viol_o;
   logic       legal_o;
   int checks = 0, errors = 0;
   int got_op, got_code, got_legal;

   always #2.5 clk = ~clk;

   sdram_cmd_checker #(.NUM_BANKS(NB), .BL(BL), .TRCD(TRCD), .TRAS(TRAS),
                       .TRP(TRP), .TWR(TWR)) u_dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
      .op_o(op_o), .legal_o(legal_o), .viol_o(viol_o));

   task automatic raw(input bit c, input bit r, input bit ca, input bit w,
                      input bit k, input int b, input bit a);
      cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = 2'(b); a10 = a;
      @(negedge clk);
      got_op = int'(op_o); got_code = int'(viol_o); got_legal = int'(legal_o);
      cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cke = 1'b1; a10 = 1'b0;
   endtask

   function automatic logic [2:0] pins(input int op);
      case (op)
         ACT: return 3'b011;  RD:  return 3'b101;  WR:  return 3'b100;
         PRE: return 3'b010;  REF: return 3'b001;  MRS: return 3'b000;
         BST: return 3'b110;  default: return 3'b111;
      endcase
   endfunction

   task automatic issue(input int op, input int b, input bit a);
      logic [2:0] p;
      p = pins(op);
      raw(1'b0, p[2], p[1], p[0], 1'b1, b, a);
   endtask

   task automatic nops(input int n);
      for (int i = 0; i < n; i++) issue(NOP, 0, 1'b0);
   endtask

   task automatic chk(input string tag, input int eop, input int ecode);
      checks++;
      if (got_op != eop || got_code != ecode || got_legal != int'(ecode == 0)) begin
         errors++;
         $display("FAIL %s: op=%0d code=%0d legal=%0d, expected op=%0d code=%0d legal=%0d",
                  tag, got_op, got_code, got_legal, eop, ecode, int'(ecode == 0));
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic int dec(input bit c, input logic [2:0] p);
      if (c) return NOP;
      case (p)
         3'b111: return NOP; 3'b011: return ACT; 3'b101: return RD;
         3'b100: return WR;  3'b010: return PRE; 3'b001: return REF;
         3'b000: return MRS; default: return BST;
      endcase
   endfunction

   function automatic int ap_verdict(input int t, input int start);
      if (t <= start) return 1;
      if (t < start + TRP) return 3;
      return 0;
   endfunction

   initial begin : wd
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int e, st;
      // R14: reset state
      do_reset();
      @(negedge clk);
      got_op = int'(op_o); got_code = int'(viol_o); got_legal = int'(legal_o);
      chk("R14 reset outputs", NOP, 0);
      issue(RD, 0, 1'b0); chk("R14 banks closed after reset", RD, 1);
      issue(ACT, 0, 1'b0); chk("R14 timers expired after reset", ACT, 0);

      // R1/R2: decode sweep over CS_n and all strobe patterns
      for (int c = 0; c < 2; c++) begin
         for (int p = 0; p < 8; p++) begin
            do_reset();
            raw(c[0], p[2], p[1], p[0], 1'b1, 1, 1'b0);
            e = dec(c[0], 3'(p));
            chk(c ? "R2 deselect" : "R1 decode", e, (e == RD || e == WR) ? 1 : 0);
         end
      end

      // R3: CKE low ignored
      do_reset();
      raw(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0); chk("R3 cke low act", NOP, 0);
      nops(TRCD);
      issue(RD, 0, 1'b0); chk("R3 bank untouched", RD, 1);

      // R6: tRCD sweep
      for (int w = 0; w < 2; w++) begin
         for (int g = 1; g <= 4; g++) begin
            do_reset();
            issue(ACT, 1, 1'b0); nops(g - 1);
            issue(w ? WR : RD, 1, 1'b0);
            chk("R6 trcd", w ? WR : RD, (g >= TRCD) ? 0 : 2);
         end
      end

      // R7: tRAS sweep
      for (int g = 1; g <= TRAS + 2; g++) begin
         do_reset();
         issue(ACT, 2, 1'b0); nops(g - 1);
         issue(PRE, 2, 1'b0); chk("R7 tras", PRE, (g >= TRAS) ? 0 : 4);
      end
      do_reset();
      issue(PRE, 3, 1'b0); chk("R7 precharge closed bank", PRE, 0);
      issue(ACT, 3, 1'b0); chk("R7 closed precharge no effect", ACT, 0);

      // R9: tRP sweep
      for (int g = 1; g <= 4; g++) begin
         do_reset();
         issue(ACT, 0, 1'b0); nops(TRAS - 1);
         issue(PRE, 0, 1'b0); chk("R9 setup precharge", PRE, 0);
         nops(g - 1);
         issue(ACT, 0, 1'b0); chk("R9 trp", ACT, (g >= TRP) ? 0 : 3);
      end

      // R8: write recovery sweep
      for (int g = 1; g <= BLH + TWR + 2; g++) begin
         do_reset();
         issue(ACT, 3, 1'b0); nops(TRAS - 1);
         issue(WR, 3, 1'b0); chk("R8 setup write", WR, 0);
         nops(g - 1);
         issue(PRE, 3, 1'b0); chk("R8 twr", PRE, (g >= BLH + TWR) ? 0 : 5);
      end

      // R5: wrong state, no change, bank independence
      do_reset();
      issue(ACT, 0, 1'b0);
      issue(ACT, 0, 1'b0); chk("R5 act open bank", ACT, 1);
      nops(TRCD - 2);
      issue(RD, 0, 1'b0); chk("R5 illegal act kept timer", RD, 0);
      issue(WR, 1, 1'b0); chk("R5 write closed bank", WR, 1);
      issue(ACT, 1, 1'b0); chk("R5 bank1 still closed", ACT, 0);
      issue(RD, 2, 1'b0); chk("R5 bank2 independent", RD, 1);

      // R12: read with auto-precharge sweep
      for (int d = TRCD; d <= TRAS + 1; d++) begin
         for (int g = 1; g <= TRAS + TRP + 2; g++) begin
            do_reset();
            issue(ACT, 1, 1'b0); nops(d - 1);
            issue(RD, 1, 1'b1); chk("R12 read ap accepted", RD, 0);
            nops(g - 1);
            issue(ACT, 1, 1'b0);
            st = (d + BLH > TRAS) ? d + BLH : TRAS;
            chk("R12 read ap close", ACT, ap_verdict(d + g, st));
         end
      end

      // R13: write with auto-precharge sweep
      for (int d = TRCD; d <= TRAS + 1; d++) begin
         for (int g = 1; g <= TRAS + TRP + TWR + 2; g++) begin
            do_reset();
            issue(ACT, 2, 1'b0); nops(d - 1);
            issue(WR, 2, 1'b1); chk("R13 write ap accepted", WR, 0);
            nops(g - 1);
            issue(ACT, 2, 1'b0);
            st = (d + BLH + TWR > TRAS) ? d + BLH + TWR : TRAS;
            chk("R13 write ap close", ACT, ap_verdict(d + g, st));
         end
      end

      // R10: refresh and mode set need all banks closed and tRP expired
      do_reset();
      issue(REF, 0, 1'b0); chk("R10 refresh all idle", REF, 0);
      issue(ACT, 1, 1'b0);
      issue(REF, 0, 1'b0); chk("R10 refresh open bank", REF, 1);
      issue(MRS, 0, 1'b0); chk("R10 mode set open bank", MRS, 1);
      for (int g = 1; g <= 3; g++) begin
         do_reset();
         issue(ACT, 1, 1'b0); nops(TRAS - 1);
         issue(PRE, 0, 1'b1); chk("R11 precharge all", PRE, 0);
         nops(g - 1);
         issue(REF, 0, 1'b0); chk("R10 refresh trp", REF, (g >= TRP) ? 0 : 3);
      end

      // R11: all-bank and single-bank precharge
      do_reset();
      issue(ACT, 0, 1'b0); issue(ACT, 2, 1'b0); nops(TRAS - 1);
      issue(PRE, 1, 1'b1); chk("R11 precharge all legal", PRE, 0);
      issue(RD, 2, 1'b0); chk("R11 bank2 closed", RD, 1);
      issue(RD, 0, 1'b0); chk("R11 bank0 closed", RD, 1);
      do_reset();
      issue(ACT, 3, 1'b0);
      issue(PRE, 0, 1'b1); chk("R11 precharge all too early", PRE, 4);
      do_reset();
      issue(ACT, 0, 1'b0); issue(ACT, 1, 1'b0); nops(TRAS);
      issue(PRE, 0, 1'b0); chk("R11 single precharge", PRE, 0);
      issue(RD, 1, 1'b0); chk("R11 other bank open", RD, 0);
      issue(RD, 0, 1'b0); chk("R11 target bank closed", RD, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule